// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Leg Pair

This block drives the two legs of a phase-shifted full bridge. It has two PWM channels, a leading channel and a lagging channel. Each channel has an up-counting timebase, and its action stage turns the counter into a square wave. Each channel then feeds a dead-band stage. That stage produces an active-high complementary pair of gate signals. The edge that turns a switch on is held back by a programmable delay, one for each output. The leading channel emits a sync pulse each time its counter is at zero. On that pulse the lagging channel jumps its counter to a programmed phase position. The phase angle between the two legs is therefore set only by that phase value.

Period, compare and phase values are written through a configuration strobe into shadow copies. A channel copies them into its working registers only at its own counter zero, or while the block is stopped. Both timebases start on the same clock edge when the global start is raised. The lagging channel keeps its outputs low until it has taken its first sync and jumped to its phase position. Its first drive pulse therefore already carries the programmed shift and never lines up with the first pulse of the leading channel. Each channel has a one-shot trip latch. The latch forces the outputs of that channel low and is released only by a clear strobe.

Top module: `psfb_leg_pair`

## Requirements
- R1: While running, each timebase counts 0, 1, … up to the working period value P and then returns to 0, so a full cycle lasts P+1 clocks. The time from one rising edge of m_a to the next is therefore P+1 clocks.
- R2: The leading channel's action signal is high while its counter is below the compare value C and low otherwise. Seen at the pins, each m_a pulse lasts C−RED clocks and each m_b pulse lasts (P+1−C)−FED clocks.
- R3: The lagging channel's action signal has the opposite polarity: high while its counter is at or above C. Each s_a pulse lasts (P+1−C)−RED clocks and each s_b pulse lasts C−FED clocks.
- R4: The dead-band stage derives both outputs of a channel from its action signal. The A output rises RED clocks after the action signal rises. The B output, the inverse, rises FED clocks after the action signal falls. Both outputs drop at once when their half ends, so the two outputs of a channel are never high together.
- R5: In the cycle where sync_out is high, the lagging counter effectively sits at the phase value PH. The time from a rising edge of m_a to the next rising edge of s_b, taken modulo P+1, is ((P+1−PH) mod (P+1)) + FED − RED. A phase of 0 puts both legs in step.
- R6: A phase value above the period is treated as equal to the period.
- R7: A configuration write during a cycle leaves the period and compare of the current cycle unchanged. The new values apply from the next counter zero of that channel.
- R8: While start is low, both counters are held at zero and all four outputs and sync_out are low. Raising start sets both timebases running on the same edge. sync_out pulses once per leading-channel cycle, only while running.
- R9: The lagging channel's outputs stay low until its first sync has been taken. Its first s_b pulse after start lasts C−PH−FED clocks, when PH+1 < C: it covers only the part of the first cycle that follows the phase position.
- R10: Reset sets both trip latches. A high trip input sets the latch of its own channel. While a latch is set, both outputs of that channel are low from the next clock on, and the other channel runs on. Only a trip_clr strobe releases a latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Global run enable for both timebases |
| cfg_we | input | 1 | Write strobe for all configuration inputs |
| cfg_period | input | CNT_W | Period value P, shadowed |
| cfg_cmp_m | input | CNT_W | Leading-channel compare C, shadowed |
| cfg_cmp_s | input | CNT_W | Lagging-channel compare C, shadowed |
| cfg_phase | input | CNT_W | Phase position PH of the lagging counter, shadowed |
| cfg_red | input | DB_W | Delay RED on the rising edge of the A outputs |
| cfg_fed | input | DB_W | Delay FED on the rising edge of the B outputs |
| trip_m | input | 1 | Sets the leading-channel trip latch |
| trip_s | input | 1 | Sets the lagging-channel trip latch |
| trip_clr | input | 1 | Clears both trip latches |
| m_a | output | 1 | Leading leg, upper switch drive |
| m_b | output | 1 | Leading leg, lower switch drive |
| s_a | output | 1 | Lagging leg, upper switch drive |
| s_b | output | 1 | Lagging leg, lower switch drive |
| sync_out | output | 1 | Sync pulse at leading-counter zero, passed on by the lagging channel |

## Verification
The bench builds the block with an 8-bit counter and 4-bit delays, a period of 39, compares of 20, a phase of 10 and delays of 3 and 5. With these values a full switching cycle is only 40 clocks, so one short run can measure pulse widths, dead gaps and the leg-to-leg shift over many cycles. Because the two delays differ, an error that swaps or misroutes them changes a measured number. The small period also brings two cases within reach: a phase above the period, which tests the clamp, and a period change that retimes the wrap within a few cycles.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

    // Role of a channel inside the leg pair
    typedef enum logic {
        ROLE_LEAD = 1'b0,
        ROLE_LAG  = 1'b1
    } role_e;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase
    import psfb_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned DEF_PERIOD = 3000,
    parameter int unsigned DEF_CMP    = 1500,
    parameter int unsigned DEF_PHASE  = 0,
    parameter role_e       ROLE       = ROLE_LEAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_cmp,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic             sync_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             sync_o,
    output logic             armed_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] cmp_sh;
        logic [CNT_W-1:0] ph_sh;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] ph;
        logic             armed;
    } tb_state_t;

    localparam tb_state_t RST_STATE = '{
        cnt:    '0,
        per_sh: CNT_W'(DEF_PERIOD),
        cmp_sh: CNT_W'(DEF_CMP),
        ph_sh:  CNT_W'(DEF_PHASE),
        per:    CNT_W'(DEF_PERIOD),
        cmp:    CNT_W'(DEF_CMP),
        ph:     CNT_W'(DEF_PHASE),
        armed:  1'b0
    };

    tb_state_t        st_d, st_q;
    logic             at_zero;
    logic             take_sync;
    logic [CNT_W-1:0] ph_eff;

    assign at_zero   = run && (st_q.cnt == '0);
    assign take_sync = (ROLE == ROLE_LAG) && sync_in;
    // phase limited to the working period
    assign ph_eff    = (st_q.ph > st_q.per) ? st_q.per : st_q.ph;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.per_sh = cfg_period;
            st_d.cmp_sh = cfg_cmp;
            st_d.ph_sh  = cfg_phase;
        end
        // shadow to working copy only at own zero or while stopped
        if (!run || at_zero) begin
            st_d.per = st_q.per_sh;
            st_d.cmp = st_q.cmp_sh;
            st_d.ph  = st_q.ph_sh;
        end
        if (!run) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else if (take_sync) begin
            // counter stands at the phase during the sync cycle,
            // so it holds the phase plus one on the following one
            st_d.cnt   = (ph_eff >= st_q.per) ? '0 : ph_eff + ONE;
            st_d.armed = 1'b1;
        end else begin
            st_d.cnt = (st_q.cnt >= st_q.per) ? '0 : st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign cmp_o = st_q.cmp;

    generate
        if (ROLE == ROLE_LEAD) begin : g_lead
            assign sync_o  = at_zero;
            assign armed_o = run;
        end else begin : g_lag
            assign sync_o  = sync_in;
            assign armed_o = st_q.armed;
        end
    endgenerate

endmodule

// File: rtl/psfb_action.sv
module psfb_action
    import psfb_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter role_e       ROLE  = ROLE_LEAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    output logic             act_o
);

    typedef struct packed {
        logic act;
    } act_state_t;

    act_state_t st_d, st_q;
    logic       below;

    assign below = (cnt < cmp);

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.act = 1'b0;
        end else if (ROLE == ROLE_LEAD) begin
            // high from zero up to the compare point
            st_d.act = below;
        end else begin
            // low from zero, high from the compare point on
            st_d.act = !below;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
    parameter int unsigned DB_W    = 8,
    parameter int unsigned DEF_RED = 90,
    parameter int unsigned DEF_FED = 90
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            act,
    input  logic            cfg_we,
    input  logic [DB_W-1:0] cfg_red,
    input  logic [DB_W-1:0] cfg_fed,
    output logic            a_o,
    output logic            b_o
);

    localparam logic [DB_W-1:0] RUN_MAX = {DB_W{1'b1}};
    localparam logic [DB_W-1:0] ONE     = DB_W'(1);

    typedef struct packed {
        logic            prev;
        logic [DB_W-1:0] run_len;
        logic [DB_W-1:0] red;
        logic [DB_W-1:0] fed;
        logic            a;
        logic            b;
    } db_state_t;

    localparam db_state_t RST_STATE = '{
        prev:    1'b0,
        run_len: '0,
        red:     DB_W'(DEF_RED),
        fed:     DB_W'(DEF_FED),
        a:       1'b0,
        b:       1'b0
    };

    db_state_t       st_d, st_q;
    logic [DB_W-1:0] age;

    // clocks since the action signal last changed, saturating
    assign age = (act != st_q.prev) ? '0 : st_q.run_len;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.red = cfg_red;
            st_d.fed = cfg_fed;
        end
        if (hold) begin
            st_d.prev    = 1'b0;
            st_d.run_len = '0;
            st_d.a       = 1'b0;
            st_d.b       = 1'b0;
        end else begin
            st_d.prev    = act;
            st_d.run_len = (age == RUN_MAX) ? RUN_MAX : age + ONE;
            st_d.a       = act  && (age >= st_q.red);
            st_d.b       = !act && (age >= st_q.fed);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign a_o = st_q.a;
    assign b_o = st_q.b;

endmodule

// File: rtl/psfb_trip.sv
module psfb_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic clr,
    output logic tripped_o
);

    typedef struct packed {
        logic tripped;
    } trip_state_t;

    trip_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip)     st_d.tripped = 1'b1;
        else if (clr) st_d.tripped = 1'b0;
    end

    // latch comes out of reset set: drive stays off until cleared
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tripped: 1'b1};
        else        st_q <= st_d;
    end

    assign tripped_o = st_q.tripped;

endmodule

// File: rtl/psfb_leg_pair.sv
module psfb_leg_pair
    import psfb_pkg::*;
#(
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned DB_W       = 8,
    parameter int unsigned DEF_PERIOD = 3000,
    parameter int unsigned DEF_CMP    = 1500,
    parameter int unsigned DEF_PHASE  = 0,
    parameter int unsigned DEF_RED    = 90,
    parameter int unsigned DEF_FED    = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_cmp_m,
    input  logic [CNT_W-1:0] cfg_cmp_s,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic [DB_W-1:0]  cfg_red,
    input  logic [DB_W-1:0]  cfg_fed,
    input  logic             trip_m,
    input  logic             trip_s,
    input  logic             trip_clr,
    output logic             m_a,
    output logic             m_b,
    output logic             s_a,
    output logic             s_b,
    output logic             sync_out
);

    logic [NUM_CH-1:0] sync_w;
    logic [NUM_CH-1:0] out_a;
    logic [NUM_CH-1:0] out_b;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            localparam role_e CH_ROLE = (ch == 0) ? ROLE_LEAD : ROLE_LAG;

            logic [CNT_W-1:0] cnt_w;
            logic [CNT_W-1:0] cmp_w;
            logic [CNT_W-1:0] cmp_cfg_w;
            logic             sync_in_w;
            logic             trip_in_w;
            logic             armed_w;
            logic             act_w;
            logic             a_w;
            logic             b_w;
            logic             tripped_w;

            if (ch == 0) begin : g_lead_in
                assign sync_in_w = 1'b0;
                assign cmp_cfg_w = cfg_cmp_m;
                assign trip_in_w = trip_m;
            end else begin : g_lag_in
                assign sync_in_w = sync_w[0];
                assign cmp_cfg_w = cfg_cmp_s;
                assign trip_in_w = trip_s;
            end

            psfb_timebase #(
                .CNT_W      (CNT_W),
                .DEF_PERIOD (DEF_PERIOD),
                .DEF_CMP    (DEF_CMP),
                .DEF_PHASE  (DEF_PHASE),
                .ROLE       (CH_ROLE)
            ) u_tb (
                .clk        (clk),
                .rst_n      (rst_n),
                .run        (start),
                .cfg_we     (cfg_we),
                .cfg_period (cfg_period),
                .cfg_cmp    (cmp_cfg_w),
                .cfg_phase  (cfg_phase),
                .sync_in    (sync_in_w),
                .cnt_o      (cnt_w),
                .cmp_o      (cmp_w),
                .sync_o     (sync_w[ch]),
                .armed_o    (armed_w)
            );

            psfb_action #(
                .CNT_W (CNT_W),
                .ROLE  (CH_ROLE)
            ) u_act (
                .clk   (clk),
                .rst_n (rst_n),
                .hold  (!armed_w),
                .cnt   (cnt_w),
                .cmp   (cmp_w),
                .act_o (act_w)
            );

            psfb_deadband #(
                .DB_W    (DB_W),
                .DEF_RED (DEF_RED),
                .DEF_FED (DEF_FED)
            ) u_db (
                .clk     (clk),
                .rst_n   (rst_n),
                .hold    (!armed_w),
                .act     (act_w),
                .cfg_we  (cfg_we),
                .cfg_red (cfg_red),
                .cfg_fed (cfg_fed),
                .a_o     (a_w),
                .b_o     (b_w)
            );

            psfb_trip u_trip (
                .clk       (clk),
                .rst_n     (rst_n),
                .trip      (trip_in_w),
                .clr       (trip_clr),
                .tripped_o (tripped_w)
            );

            assign out_a[ch] = a_w & armed_w & ~tripped_w;
            assign out_b[ch] = b_w & armed_w & ~tripped_w;
        end
    endgenerate

    assign m_a      = out_a[0];
    assign m_b      = out_b[0];
    assign s_a      = out_a[1];
    assign s_b      = out_b[1];
    assign sync_out = sync_w[NUM_CH-1];

endmodule

// File: rtl/psfb_leg_pair_chk.sv
module psfb_leg_pair_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic trip_m,
    input logic trip_s,
    input logic m_a,
    input logic m_b,
    input logic s_a,
    input logic s_b,
    input logic sync_out
);

    // R4: the two switches of one leg never conduct together
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_a && m_b) && !(s_a && s_b));

    // R8: one clock after start is low every drive is off
    assert_stop_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !(m_a || m_b || s_a || s_b));

    // R8: sync pulses appear only while running
    assert_sync_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> start);

    // R9: the lagging leg stays off in the cycle after start rises
    assert_lag_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start) |=> !s_a && !s_b);

    // R10: a trip on the leading leg silences it on the next clock
    assert_trip_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trip_m |=> !m_a && !m_b);

    // R10: a trip on the lagging leg silences it on the next clock
    assert_trip_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trip_s |=> !s_a && !s_b);

endmodule

bind psfb_leg_pair psfb_leg_pair_chk chk_i (.*);

// File: tb/psfb_leg_pair_tb.sv
`timescale 1ns/1ps
module psfb_leg_pair_tb_top;

    localparam int CW  = 8;
    localparam int DW  = 4;
    localparam int P   = 39;
    localparam int C   = 20;
    localparam int PH  = 10;
    localparam int RED = 3;
    localparam int FED = 5;
    localparam int P1  = P + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_period = CW'(P);
    logic [CW-1:0] cfg_cmp_m = CW'(C);
    logic [CW-1:0] cfg_cmp_s = CW'(C);
    logic [CW-1:0] cfg_phase = CW'(PH);
    logic [DW-1:0] cfg_red = DW'(RED);
    logic [DW-1:0] cfg_fed = DW'(FED);
    logic          trip_m = 1'b0;
    logic          trip_s = 1'b0;
    logic          trip_clr = 1'b0;
    logic          m_a, m_b, s_a, s_b, sync_out;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int overlap = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    psfb_leg_pair #(
        .CNT_W(CW), .DB_W(DW), .DEF_PERIOD(P), .DEF_CMP(C),
        .DEF_PHASE(PH), .DEF_RED(RED), .DEF_FED(FED)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
        .cfg_period(cfg_period), .cfg_cmp_m(cfg_cmp_m), .cfg_cmp_s(cfg_cmp_s),
        .cfg_phase(cfg_phase), .cfg_red(cfg_red), .cfg_fed(cfg_fed),
        .trip_m(trip_m), .trip_s(trip_s), .trip_clr(trip_clr),
        .m_a(m_a), .m_b(m_b), .s_a(s_a), .s_b(s_b), .sync_out(sync_out)
    );

    always @(negedge clk)
        if (rst_n && ((m_a && m_b) || (s_a && s_b))) overlap++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int idx);
        case (idx)
            0: return m_a;
            1: return m_b;
            2: return s_a;
            default: return s_b;
        endcase
    endfunction

    // waits for an edge on output idx, returns its cycle or -1
    task automatic wait_edge(input int idx, input bit rising, input int limit, output int t);
        logic prev, cur;
        prev = sig(idx);
        t = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            cur = sig(idx);
            if (rising ? (cur && !prev) : (!cur && prev)) begin
                t = cyc;
                return;
            end
            prev = cur;
        end
    endtask

    task automatic cfg_write();
        @(negedge clk) cfg_we = 1'b1;
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic pulse_width(input int idx, output int w);
        int tr, tf;
        wait_edge(idx, 1'b1, 200, tr);
        wait_edge(idx, 1'b0, 200, tf);
        w = (tr < 0 || tf < 0) ? -1 : tf - tr;
    endtask

    task automatic shift_meas(output int s);
        int t1, t2;
        wait_edge(0, 1'b1, 200, t1);
        wait_edge(3, 1'b1, 200, t2);
        s = (t1 < 0 || t2 < 0) ? -1 : (t2 - t1) % P1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R8 reset outputs", {m_a, m_b, s_a, s_b, sync_out}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 idle after reset", {m_a, m_b, s_a, s_b, sync_out}, 0);
    endtask

    task automatic t_trip_at_reset();
        int hi = 0;
        start = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (m_a || m_b || s_a || s_b) hi++;
        end
        chk("R10 latch set by reset keeps drives low", hi, 0);
        start = 1'b0;
        @(negedge clk) trip_clr = 1'b1;
        @(negedge clk) trip_clr = 1'b0;
    endtask

    task automatic t_startup();
        int w, syncs = 0;
        start = 1'b1;
        pulse_width(3, w);
        chk("R9 first s_b pulse width", w, C - PH - FED);
        for (int i = 0; i < 4 * P1; i++) begin
            @(negedge clk);
            if (sync_out) syncs++;
        end
        chk("R8 sync pulses per 4 cycles", syncs, 4);
    endtask

    task automatic t_steady();
        int w, t1, t2;
        wait_edge(0, 1'b1, 200, t1);
        wait_edge(0, 1'b1, 200, t2);
        chk("R1 m_a rise to rise", t2 - t1, P1);
        pulse_width(0, w); chk("R2 m_a width", w, C - RED);
        pulse_width(1, w); chk("R2 m_b width", w, P1 - C - FED);
        pulse_width(2, w); chk("R3 s_a width", w, P1 - C - RED);
        pulse_width(3, w); chk("R3 s_b width", w, C - FED);
        wait_edge(0, 1'b0, 200, t1);
        wait_edge(1, 1'b1, 200, t2);
        chk("R4 gap m_a fall to m_b rise", t2 - t1, FED);
        wait_edge(1, 1'b0, 200, t1);
        wait_edge(0, 1'b1, 200, t2);
        chk("R4 gap m_b fall to m_a rise", t2 - t1, RED);
    endtask

    task automatic t_phase(input int ph, input string req);
        int s, eff;
        cfg_phase = CW'(ph);
        cfg_write();
        repeat (3 * P1) @(negedge clk);
        eff = (ph > P) ? P : ph;
        shift_meas(s);
        chk(req, s, (((P1 - eff) % P1) + FED - RED) % P1);
    endtask

    task automatic t_cmp_shadow();
        int tr, tf, w;
        wait_edge(0, 1'b1, 200, tr);
        cfg_cmp_m = CW'(10);
        cfg_write();
        wait_edge(0, 1'b0, 200, tf);
        chk("R7 compare held within cycle", tf - tr, C - RED);
        pulse_width(0, w);
        chk("R7 compare applied next cycle", w, 10 - RED);
        cfg_cmp_m = CW'(C);
        cfg_write();
        repeat (2 * P1) @(negedge clk);
    endtask

    task automatic t_period_shadow();
        int t1, t2, t3;
        wait_edge(0, 1'b1, 200, t1);
        cfg_period = CW'(59);
        cfg_write();
        wait_edge(0, 1'b1, 200, t2);
        wait_edge(0, 1'b1, 200, t3);
        chk("R7 period held within cycle", t2 - t1, P1);
        chk("R7 period applied next cycle", t3 - t2, 60);
        cfg_period = CW'(P);
        cfg_write();
        repeat (3 * 60) @(negedge clk);
    endtask

    task automatic t_trip_lag();
        int lag_hi = 0, lead_rise = 0, t;
        logic prev;
        @(negedge clk) trip_s = 1'b1;
        @(negedge clk) trip_s = 1'b0;
        prev = m_a;
        for (int i = 0; i < 3 * P1; i++) begin
            @(negedge clk);
            if (s_a || s_b) lag_hi++;
            if (m_a && !prev) lead_rise++;
            prev = m_a;
        end
        chk("R10 tripped leg stays low", lag_hi, 0);
        chk("R10 other leg keeps switching", lead_rise, 3);
        @(negedge clk) trip_clr = 1'b1;
        @(negedge clk) trip_clr = 1'b0;
        wait_edge(3, 1'b1, 2 * P1, t);
        chk("R10 clear releases leg", (t >= 0) ? 1 : 0, 1);
    endtask

    task automatic t_stop();
        int hi = 0;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (m_a || m_b || s_a || s_b || sync_out) hi++;
        end
        chk("R8 stopped outputs low", hi, 0);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_trip_at_reset();
        t_startup();
        t_steady();
        t_phase(PH, "R5 shift at phase 10");
        t_phase(0, "R5 shift at phase 0");
        t_phase(100, "R6 phase above period clamped");
        t_phase(PH, "R5 shift restored");
        t_cmp_shadow();
        t_period_shadow();
        t_trip_lag();
        t_stop();
        chk("R4 overlap count", overlap, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule